// File: doc/BRIEF.md
# Multi-cycle 16-bit processor sequencer

This block is the controller and datapath of a small 16-bit processor with sixteen general registers. Every instruction passes through a fetch state and a decode state, then spends one or two further states on execution, memory access and register write-back before the next fetch. It holds the program counter, the instruction register, the two operand latches, a four-bit flag register and a 16x16 register file. It drives the address, write data and write strobe of a single-port, word-addressed synchronous RAM. Read data from that RAM returns one cycle after the address.

Arithmetic and logic are left to an external ALU. The core presents the opcode, a four-bit mode field and two operands to it, and takes back a result and four flags. Software sees a register-to-register ALU group and a compare that sets condition bits. It also has flag-conditioned relative branches, absolute jumps with an optional link, and a register jump. Loads can take the word that follows the instruction or a word a short distance ahead of it, and indexed loads and stores are always based on register 1.

Top module: `mc16_core`

## Requirements
- R1: While rst_ni is low the PC is 0, the controller is in FETCH, all registers read as zero and mem_we_o is low. Asserting rst_ni at any time clears the PC again at once.
- R2: Every instruction takes a FETCH cycle, which reads mem[PC] and increments the PC, and then a DECODE cycle. ALU, compare, jump, branch and unused opcodes then take one EXEC cycle, for 3 cycles in all. A store takes one MEM cycle, for 3 cycles. Both loads take MEM and WB, for 4 cycles.
- R3: The instruction word is op[15:12], rs[11:8], rt[7:4], rd[3:0]. Opcodes 0000 add, 0001 sub, 0010 and, 0011 or and 0100 xor write the ALU result into rd, with operand A taken from rs and operand B from rt.
- R4: Opcode 0101 (shift) passes the rd field to the ALU on alu_mode_o and writes the result back into rs.
- R5: Opcode 1000 with imm[7:0] = 0 loads the word at PC+1 into rs, and execution resumes at the word after that data word.
- R6: Opcode 1000 with a nonzero immediate loads mem[instruction address + 1 + imm] (imm zero-extended) into rs, and execution resumes at instruction address + 1.
- R7: Opcode 1011 loads rs from mem[r1 + imm]. Opcode 1100 stores rs to mem[r1 + imm]. Only the store raises mem_we_o.
- R8: The ALU flag word is alu_f_i[3:2] compare code (10 less, 01 equal, 00 greater), [1] overflow and [0] carry. Opcode 0110 captures only bits 3:2. Add, sub and shift capture only bits 1:0. All other instructions leave the flags unchanged.
- R9: Opcode 1010 branches to instruction address + 1 + sign-extended imm[7:0] when the condition in rs holds. The conditions are 0 less, 1 equal, 2 less-or-equal, 3 greater, 4 overflow, 5 carry, 6 overflow or carry, 7 always, and 8 to 15 never.
- R10: Opcode 1101 loads the PC with the low address bits of imm[11:0]. Opcode 1110 does the same and also writes the return address into r15. Opcode 0111 loads the PC from rs.
- R11: Opcodes 1001 and 1111 change no register, flag or memory word and take 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | AW | RAM word address |
| mem_wdata_o | output | DW | RAM write data |
| mem_we_o | output | 1 | RAM write strobe |
| mem_rdata_i | input | DW | RAM read data, one cycle after the address |
| alu_op_o | output | 4 | Opcode presented to the ALU |
| alu_mode_o | output | 4 | Shift mode field presented to the ALU |
| alu_a_o | output | DW | ALU operand A (rs) |
| alu_b_o | output | DW | ALU operand B (rt) |
| alu_y_i | input | DW | ALU result |
| alu_f_i | input | 4 | ALU flags: compare code, overflow, carry |

## Verification
The bench builds the core with AW=8, DW=16 and NR=16, which is the full 256-word memory and all sixteen registers. With these values r15 can be reached as the link register, and the 8-bit address lets a negative branch offset wrap backward over a jump. Each case is a short program in a bench RAM. The bench checks the stores the program makes, and the gap in cycles between successive stores, against values worked out from the instruction latencies. Branches that must not be taken are followed by stores to addresses that are never expected.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB} state_e;

  localparam int OPW  = 4;
  localparam int IMMW = 8;
  localparam int NFL  = 4;

  localparam logic [OPW-1:0] OP_ADD  = 4'h0;
  localparam logic [OPW-1:0] OP_SUB  = 4'h1;
  localparam logic [OPW-1:0] OP_AND  = 4'h2;
  localparam logic [OPW-1:0] OP_OR   = 4'h3;
  localparam logic [OPW-1:0] OP_XOR  = 4'h4;
  localparam logic [OPW-1:0] OP_SHFT = 4'h5;
  localparam logic [OPW-1:0] OP_SET  = 4'h6;
  localparam logic [OPW-1:0] OP_JR   = 4'h7;
  localparam logic [OPW-1:0] OP_LWI  = 4'h8;
  localparam logic [OPW-1:0] OP_BR   = 4'hA;
  localparam logic [OPW-1:0] OP_LWX  = 4'hB;
  localparam logic [OPW-1:0] OP_SWX  = 4'hC;
  localparam logic [OPW-1:0] OP_J    = 4'hD;
  localparam logic [OPW-1:0] OP_JAL  = 4'hE;

  localparam int IDX_REG  = 1;
  localparam int LINK_REG = 15;
endpackage

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [OPW-1:0] op_i,
  output state_e         state_o
);
  state_e state_d;

  always_comb begin
    state_d = S_FETCH;
    unique case (state_o)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: state_d = (op_i == OP_LWI || op_i == OP_LWX || op_i == OP_SWX) ? S_MEM : S_EXEC;
      S_MEM:    state_d = (op_i == OP_SWX) ? S_FETCH : S_WB;
      default:  state_d = S_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= S_FETCH;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/mc16_cond.sv
module mc16_cond
  import mc16_pkg::*;
(
  input  logic [NFL-1:0] flags_i,
  input  logic [3:0]     sel_i,
  output logic           take_o
);
  logic [1:0] cmp;
  logic       ovf, cry;

  assign cmp = flags_i[3:2];
  assign ovf = flags_i[1];
  assign cry = flags_i[0];

  always_comb begin
    unique case (sel_i)
      4'd0:    take_o = (cmp == 2'b10);
      4'd1:    take_o = (cmp == 2'b01);
      4'd2:    take_o = (cmp != 2'b00);
      4'd3:    take_o = (cmp == 2'b00);
      4'd4:    take_o = ovf;
      4'd5:    take_o = cry;
      4'd6:    take_o = ovf | cry;
      4'd7:    take_o = 1'b1;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int DW = 16,
  parameter int NR = 16,
  localparam int RW = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] ra1_i,
  input  logic [RW-1:0] ra2_i,
  output logic [DW-1:0] rd1_o,
  output logic [DW-1:0] rd2_o,
  input  logic          we_i,
  input  logic [RW-1:0] wa_i,
  input  logic [DW-1:0] wd_i
);
  logic [DW-1:0] regs [NR];

  for (genvar g = 0; g < NR; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= '0;
      else if (we_i && wa_i == RW'(g))        q <= wd_i;
    end
    assign regs[g] = q;
  end

  assign rd1_o = regs[ra1_i];
  assign rd2_o = regs[ra2_i];
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int NR = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  output logic           mem_we_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic [3:0]     alu_op_o,
  output logic [3:0]     alu_mode_o,
  output logic [DW-1:0]  alu_a_o,
  output logic [DW-1:0]  alu_b_o,
  input  logic [DW-1:0]  alu_y_i,
  input  logic [NFL-1:0] alu_f_i
);
  localparam int RW = $clog2(NR);

  state_e          state;
  logic [AW-1:0]   pc_q;
  logic [DW-1:0]   ir_q, a_q, b_q;
  logic [NFL-1:0]  flags_q;

  logic [DW-1:0]   instr;
  logic [OPW-1:0]  op;
  logic [3:0]      f_rs, f_rt, f_rd;
  logic [IMMW-1:0] imm8;
  logic signed [IMMW-1:0] imm_s;
  logic [AW-1:0]   br_off, pc_inc;
  logic            take;

  logic [RW-1:0]   ra2, rf_wa;
  logic [DW-1:0]   rd1, rd2, rf_wd;
  logic            rf_we;

  // during DECODE the word arriving from memory is decoded directly
  assign instr  = (state == S_DECODE) ? mem_rdata_i : ir_q;
  assign op     = instr[15:12];
  assign f_rs   = instr[11:8];
  assign f_rt   = instr[7:4];
  assign f_rd   = instr[3:0];
  assign imm8   = instr[7:0];
  assign imm_s  = imm8;
  assign br_off = AW'(imm_s);
  assign pc_inc = pc_q + AW'(1);

  assign ra2 = (op == OP_LWX || op == OP_SWX) ? RW'(IDX_REG) : f_rt[RW-1:0];

  mc16_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .state_o (state)
  );

  mc16_regfile #(.DW(DW), .NR(NR)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra1_i  (f_rs[RW-1:0]),
    .ra2_i  (ra2),
    .rd1_o  (rd1),
    .rd2_o  (rd2),
    .we_i   (rf_we),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd)
  );

  mc16_cond u_cond (
    .flags_i (flags_q),
    .sel_i   (f_rs),
    .take_o  (take)
  );

  assign alu_op_o    = ir_q[15:12];
  assign alu_mode_o  = ir_q[3:0];
  assign alu_a_o     = a_q;
  assign alu_b_o     = b_q;
  assign mem_wdata_o = a_q;
  assign mem_we_o    = (state == S_MEM) && (op == OP_SWX);

  always_comb begin
    mem_addr_o = pc_q;
    if (state == S_MEM) begin
      if (op == OP_LWI)
        mem_addr_o = (imm8 == '0) ? pc_q : pc_q + AW'(imm8);
      else
        mem_addr_o = b_q[AW-1:0] + AW'(imm8);
    end
  end

  always_comb begin
    rf_we = 1'b0;
    rf_wa = f_rd[RW-1:0];
    rf_wd = alu_y_i;
    if (state == S_EXEC) begin
      unique case (op)
        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: rf_we = 1'b1;
        OP_SHFT: begin
          rf_we = 1'b1;
          rf_wa = f_rs[RW-1:0];
        end
        OP_JAL: begin
          rf_we = 1'b1;
          rf_wa = RW'(LINK_REG);
          rf_wd = DW'(pc_q);
        end
        default: ;
      endcase
    end else if (state == S_WB) begin
      rf_we = 1'b1;
      rf_wa = f_rs[RW-1:0];
      rf_wd = mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      ir_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      flags_q <= '0;
    end else begin
      unique case (state)
        S_FETCH: pc_q <= pc_inc;
        S_DECODE: begin
          ir_q <= mem_rdata_i;
          a_q  <= rd1;
          b_q  <= rd2;
        end
        S_EXEC: begin
          unique case (op)
            OP_ADD, OP_SUB, OP_SHFT: flags_q[1:0] <= alu_f_i[1:0];
            OP_SET:                  flags_q[3:2] <= alu_f_i[3:2];
            OP_JR:                   pc_q <= a_q[AW-1:0];
            OP_BR:                   if (take) pc_q <= pc_q + br_off;
            OP_J, OP_JAL:            pc_q <= instr[AW-1:0];
            default: ;
          endcase
        end
        S_MEM: if (op == OP_LWI && imm8 == '0) pc_q <= pc_inc;  // skip inline data word
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mc16_chk.sv
module mc16_chk
  import mc16_pkg::*;
#(
  parameter int AW = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input state_e         state_i,
  input logic [AW-1:0]  pc_i,
  input logic [NFL-1:0] flags_i,
  input logic           mem_we_i
);
  p_fetch_to_decode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FETCH |=> state_i == S_DECODE);

  p_decode_route_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_DECODE |=> (state_i == S_EXEC || state_i == S_MEM));

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_FETCH |=> pc_i == $past(pc_i) + AW'(1));

  p_store_in_mem_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |-> state_i == S_MEM);

  p_flags_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != S_EXEC |=> $stable(flags_i));

  p_wb_after_mem_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == S_WB |=> state_i == S_FETCH);
endmodule

bind mc16_core mc16_chk #(.AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_i  (state),
  .pc_i     (pc_q),
  .flags_i  (flags_q),
  .mem_we_i (mem_we_o)
);

// File: tb/sim_mc16_core.sv
module sim_mc16_core;
  localparam int CLK_P = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int RUN = 200;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, alu_a, alu_b, alu_y;
  logic          mem_we;
  logic [3:0]    alu_op, alu_mode, alu_f;

  always #(CLK_P/2) clk = ~clk;

  mc16_core #(.AW(AW), .DW(DW), .NR(16)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .mem_rdata_i(mem_rdata),
    .alu_op_o(alu_op), .alu_mode_o(alu_mode), .alu_a_o(alu_a), .alu_b_o(alu_b),
    .alu_y_i(alu_y), .alu_f_i(alu_f)
  );

  // synchronous RAM model with a loader port
  logic [DW-1:0] ram [1<<AW];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_a = '0;
  logic [DW-1:0] ld_d = '0;
  always @(posedge clk) begin
    if (ld_en)       ram[ld_a] <= ld_d;
    else if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  // ALU model: f = {cmp[1:0], v, c}
  always_comb begin
    logic [DW:0] w;
    logic [1:0]  cmp;
    logic        v, c;
    w = '0; v = 1'b0; c = 1'b0;
    cmp = (alu_a < alu_b) ? 2'b10 : (alu_a == alu_b) ? 2'b01 : 2'b00;
    case (alu_op)
      4'h0: begin w = {1'b0, alu_a} + {1'b0, alu_b};
              v = (alu_a[DW-1] == alu_b[DW-1]) && (w[DW-1] != alu_a[DW-1]); end
      4'h1: begin w = {1'b0, alu_a} - {1'b0, alu_b};
              v = (alu_a[DW-1] != alu_b[DW-1]) && (w[DW-1] != alu_a[DW-1]); end
      4'h2: w = {1'b0, alu_a & alu_b};
      4'h3: w = {1'b0, alu_a | alu_b};
      4'h4: w = {1'b0, alu_a ^ alu_b};
      4'h5: w = alu_mode[3] ? {1'b0, alu_a >> alu_b[3:0]} : {1'b0, alu_a << alu_b[3:0]};
      default: w = '0;
    endcase
    c = w[DW];
    alu_y = w[DW-1:0];
    alu_f = {cmp, v, c};
  end

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int last_cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [AW-1:0] q_a [$];
  logic [DW-1:0] q_d [$];
  int            q_g [$];
  string         q_t [$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_st(input logic [AW-1:0] a, input logic [DW-1:0] d, input int gap, input string tag);
    q_a.push_back(a); q_d.push_back(d); q_g.push_back(gap); q_t.push_back(tag);
  endtask

  // monitor: pop and compare every store
  always @(negedge clk) begin
    if (rst_ni && mem_we) begin
      if (q_a.size() == 0) begin
        check(1'b0, "R7", "unexpected store", {mem_addr, mem_wdata}, 0);
      end else begin
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        int eg;
        string et;
        ea = q_a.pop_front(); ed = q_d.pop_front(); eg = q_g.pop_front(); et = q_t.pop_front();
        check(mem_addr == ea && mem_wdata == ed, et, "store addr/data", {mem_addr, mem_wdata}, {ea, ed});
        if (eg >= 0) check(cyc - last_cyc == eg, et, "cycles between stores", cyc - last_cyc, eg);
      end
      last_cyc = cyc;
    end
  end

  task automatic poke(input int a, input logic [DW-1:0] d);
    ld_en = 1'b1; ld_a = AW'(a); ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic clear_ram();
    for (int i = 0; i < (1 << AW); i++) poke(i, '0);
  endtask

  function automatic logic [15:0] enc_r(input logic [3:0] op, rs, rt, rd);
    return {op, rs, rt, rd};
  endfunction
  function automatic logic [15:0] enc_i(input logic [3:0] op, rs, input logic [7:0] imm);
    return {op, rs, imm};
  endfunction
  function automatic logic [15:0] enc_j(input logic [3:0] op, input logic [11:0] t);
    return {op, t};
  endfunction

  task automatic run_prog();
    @(negedge clk) rst_ni = 1'b1;
    repeat (RUN) @(negedge clk);
    check(q_a.size() == 0, "R2", "stores still pending", q_a.size(), 0);
    rst_ni = 1'b0;
    #1;
    check(mem_addr == '0 && !mem_we, "R1", "pc cleared by reset", mem_addr, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 20000);
    check(1'b0, "R2", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check(mem_we == 1'b0, "R1", "no store in reset", mem_we, 0);
    check(mem_addr == '0, "R1", "pc zero in reset", mem_addr, 0);

    // program 1: ALU group, inline load, latencies
    clear_ram();
    poke(0, enc_i(4'h8, 4'd2, 8'h00)); poke(1, 16'h1234);
    poke(2, enc_i(4'h8, 4'd3, 8'h00)); poke(3, 16'h0F0F);
    poke(4, enc_r(4'h0, 4'd2, 4'd3, 4'd4));
    poke(5, enc_i(4'hC, 4'd4, 8'h80));
    poke(6, enc_r(4'h1, 4'd2, 4'd3, 4'd5));
    poke(7, enc_i(4'hC, 4'd5, 8'h81));
    poke(8, enc_r(4'h2, 4'd2, 4'd3, 4'd6));
    poke(9, enc_r(4'h3, 4'd2, 4'd3, 4'd7));
    poke(10, enc_r(4'h4, 4'd2, 4'd3, 4'd8));
    poke(11, enc_i(4'hC, 4'd6, 8'h82));
    poke(12, enc_i(4'hC, 4'd7, 8'h83));
    poke(13, enc_i(4'hC, 4'd8, 8'h84));
    poke(14, enc_i(4'h8, 4'd9, 8'h00)); poke(15, 16'hBEEF);
    poke(16, enc_i(4'hC, 4'd9, 8'h85));
    poke(17, enc_j(4'hD, 12'd17));
    expect_st(8'h80, 16'h2143, -1, "R3 add");
    expect_st(8'h81, 16'h0325,  6, "R2 sub");
    expect_st(8'h82, 16'h0204, 12, "R3 and");
    expect_st(8'h83, 16'h1F3F,  3, "R2 or");
    expect_st(8'h84, 16'h1D3B,  3, "R3 xor");
    expect_st(8'h85, 16'hBEEF,  7, "R5 inline load");
    run_prog();

    // program 2: relative load, indexed access, shifts, link and return
    clear_ram();
    poke(0, enc_i(4'h8, 4'd1, 8'h00)); poke(1, 16'h0010);
    poke(2, enc_i(4'h8, 4'd2, 8'h0E));
    poke(3, enc_i(4'hC, 4'd2, 8'h70));
    poke(4, enc_i(4'hB, 4'd3, 8'h02));
    poke(5, enc_i(4'hC, 4'd3, 8'h71));
    poke(6, enc_i(4'h8, 4'd4, 8'h00)); poke(7, 16'h0004);
    poke(8, enc_r(4'h5, 4'd3, 4'd4, 4'h0));
    poke(9, enc_i(4'hC, 4'd3, 8'h72));
    poke(10, enc_r(4'h5, 4'd3, 4'd4, 4'h8));
    poke(11, enc_i(4'hC, 4'd3, 8'h73));
    poke(12, enc_j(4'hE, 12'h020));
    poke(13, enc_i(4'hC, 4'd5, 8'h74));
    poke(14, 16'h9000);
    poke(15, enc_i(4'hC, 4'd1, 8'h76));
    poke(16, enc_j(4'hD, 12'd16));
    poke(17, 16'hA5A5);
    poke(18, 16'h5A5A);
    poke(32, enc_i(4'hC, 4'd15, 8'h75));
    poke(33, enc_r(4'h7, 4'd15, 4'd0, 4'd0));
    expect_st(8'h80, 16'hA5A5, -1, "R6 relative load");
    expect_st(8'h81, 16'h5A5A, -1, "R7 indexed load");
    expect_st(8'h82, 16'hA5A0, -1, "R4 shift left");
    expect_st(8'h83, 16'h0A5A,  6, "R4 shift right");
    expect_st(8'h85, 16'h000D,  6, "R10 link reg");
    expect_st(8'h84, 16'h0000,  6, "R1 regs cleared");
    expect_st(8'h86, 16'h0010,  6, "R11 unused opcode");
    run_prog();

    // program 3: compare flags and branch conditions
    clear_ram();
    poke(0, enc_i(4'h8, 4'd2, 8'h00)); poke(1, 16'h0005);
    poke(2, enc_i(4'h8, 4'd3, 8'h00)); poke(3, 16'h0007);
    poke(4, enc_r(4'h6, 4'd2, 4'd3, 4'd0));
    poke(5, enc_i(4'hA, 4'd3, 8'h02));
    poke(6, enc_i(4'hA, 4'd0, 8'h01));
    poke(7, enc_i(4'hC, 4'd2, 8'h90));
    poke(8, enc_i(4'hC, 4'd3, 8'h91));
    poke(9, enc_r(4'h6, 4'd3, 4'd3, 4'd0));
    poke(10, enc_i(4'hA, 4'd1, 8'h01));
    poke(11, enc_i(4'hC, 4'd2, 8'h92));
    poke(12, enc_i(4'hA, 4'd2, 8'h02));
    poke(13, enc_i(4'hC, 4'd2, 8'h93));
    poke(14, enc_i(4'hC, 4'd2, 8'h93));
    poke(15, enc_i(4'h8, 4'd6, 8'h00)); poke(16, 16'hFFFF);
    poke(17, enc_r(4'h0, 4'd6, 4'd6, 4'd7));
    poke(18, enc_i(4'hA, 4'd4, 8'h01));
    poke(19, enc_i(4'hA, 4'd5, 8'h01));
    poke(20, enc_i(4'hC, 4'd2, 8'h94));
    poke(21, enc_i(4'hC, 4'd7, 8'h95));
    poke(22, enc_i(4'hA, 4'd1, 8'h01));
    poke(23, enc_i(4'hC, 4'd2, 8'h96));
    poke(24, enc_j(4'hD, 12'h030));
    poke(25, enc_i(4'hC, 4'd2, 8'h9B));
    poke(26, enc_i(4'hC, 4'd6, 8'h98));
    poke(27, enc_i(4'hA, 4'd8, 8'h01));
    poke(28, enc_i(4'hA, 4'd6, 8'h01));
    poke(29, enc_i(4'hC, 4'd2, 8'h99));
    poke(30, enc_i(4'hA, 4'd7, 8'h01));
    poke(31, enc_i(4'hC, 4'd2, 8'h9C));
    poke(32, enc_i(4'hC, 4'd7, 8'h9A));
    poke(33, enc_j(4'hD, 12'd33));
    poke(48, enc_i(4'hC, 4'd3, 8'h97));
    poke(49, enc_i(4'hA, 4'd1, 8'hE8));
    expect_st(8'h91, 16'h0007, -1, "R9 lt taken gt not");
    expect_st(8'h95, 16'hFFFE, -1, "R8 carry set, v clear");
    expect_st(8'h97, 16'h0007, -1, "R10 jump / R8 cmp kept");
    expect_st(8'h98, 16'hFFFF, -1, "R9 backward branch");
    expect_st(8'h9A, 16'hFFFE, -1, "R9 never/vc/always");
    run_prog();

    finish_run();
  end
endmodule